// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block produces the bus timing of a single opcode fetch machine cycle for an 8-bit processor. After a start request it walks the states T1, T2, zero or more wait states, T3 and T4. It places the latched program counter on the address bus. It drives the active-low strobes that mark an opcode fetch (`m1_n`), a memory request (`mreq_n`), a read (`rd_n`) and a refresh (`rfsh_n`). At the rising edge that opens T3 it captures the opcode from the data bus into an instruction register.

The last two states are reused for a refresh of dynamic memory. During T3 and T4 the address bus carries a 7-bit refresh count with zero upper bits, and the read strobe stays off. A slow memory holds `wait_n` low to stretch the read phase. The sequencer samples it on the falling edge in T2 and in every wait state.

The block runs on a clock at twice the processor clock rate, `clk2x`. An internal half signal tells the rising-edge half of each T-state from the falling-edge half. Each T-state therefore lasts two `clk2x` cycles. Half 0 follows the processor's rising edge and half 1 follows its falling edge.

Top module: `fetch_cycle_seq`

## Requirements
- R1: From the start of T1 to the end of the last read state (T2 or the last wait state), `addr` equals the value of `pc` captured in the idle cycle where `start` was accepted. In idle, `addr` is zero.
- R2: `mreq_n` and `rd_n` are high in the first half of T1. Both are low from the second half of T1 through the end of T2 and of every wait state.
- R3: `opcode` takes the value `data_in` had on the `clk2x` edge that begins T3. `ir_load` is high for exactly the first half of T3, and `opcode` holds its value at all other times.
- R4: In every half of T3 and T4, `rfsh_n` is low and `addr` equals the 7-bit refresh count in its low bits, with all upper bits zero. Outside T3 and T4, `rfsh_n` is high.
- R5: `rd_n` is high throughout T3 and T4.
- R6: In the refresh portion, `mreq_n` is high in the first half of T3, low in the second half of T3 and the first half of T4, and high in the second half of T4.
- R7: `m1_n` is low from T1 through the last read state and high from the start of T3 on, and in idle.
- R8: `wait_n` is sampled on the clock edge that opens the second half of T2 or of a wait state. A low sample causes one more wait state after the current state. A high sample leads to T3. A low `wait_n` seen at any other edge has no effect.
- R9: `done` is high for exactly the second half of T4 (one `clk2x` cycle). The next cycle is idle, with all strobes high.
- R10: While `rst` is high at a clock edge, the sequencer goes idle. All four strobes go high, `addr`, `opcode`, `ir_load` and `done` go to zero, and the refresh count is cleared.
- R11: The refresh count increases by one at the end of every fetch cycle and wraps from 127 to 0.
- R12: `start` is accepted only in idle. A `start` with a new `pc` during a fetch cycle does not change the cycle in progress or its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the processor clock rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an opcode fetch cycle |
| pc | input | 16 | Program counter value to fetch from |
| wait_n | input | 1 | Active-low wait request from memory |
| data_in | input | 8 | Data bus from memory |
| addr | output | 16 | Address bus |
| m1_n | output | 1 | Active-low opcode fetch marker |
| mreq_n | output | 1 | Active-low memory request |
| rd_n | output | 1 | Active-low read strobe |
| rfsh_n | output | 1 | Active-low refresh marker |
| ir_load | output | 1 | High in the cycle after the opcode was captured |
| opcode | output | 8 | Instruction register |
| done | output | 1 | Pulse at the end of the fetch cycle |

## Verification
The bench keeps its own model of the T-state sequence and drives `wait_n` low in both halves of each state. A design that samples on the wrong half would stretch or shorten the read phase, and the address, strobe and capture timing would then move against the model. Starts arrive during busy cycles and right at `done`, so a sequencer that restarts mid-cycle or drops a back-to-back request shows up at once. The fetch count is driven past 128 to expose a counter that fails to wrap or that steps at the wrong time. Every refresh half is watched for a read strobe that leaks into T3 or T4, and for a memory request whose edges sit in the wrong half.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } tstate_e;

    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic rd_n;
        logic rfsh_n;
    } strobes_t;

    localparam strobes_t STROBES_OFF = '{m1_n: 1'b1, mreq_n: 1'b1, rd_n: 1'b1, rfsh_n: 1'b1};

    // True in the states where the memory is being read
    function automatic logic is_read_state(tstate_e st);
        return (st == ST_T2) || (st == ST_TW);
    endfunction

    // True in the states that carry the hidden refresh
    function automatic logic is_refresh_state(tstate_e st);
        return (st == ST_T3) || (st == ST_T4);
    endfunction

    // Strobe levels for a given T-state and half (0: after rise, 1: after fall)
    function automatic strobes_t strobes_for(tstate_e st, logic hf);
        strobes_t s;
        s = STROBES_OFF;
        case (st)
            ST_T1: begin
                s.m1_n   = 1'b0;
                s.mreq_n = ~hf;
                s.rd_n   = ~hf;
            end
            ST_T2, ST_TW: begin
                s.m1_n   = 1'b0;
                s.mreq_n = 1'b0;
                s.rd_n   = 1'b0;
            end
            ST_T3: begin
                s.rfsh_n = 1'b0;
                s.mreq_n = ~hf;
            end
            ST_T4: begin
                s.rfsh_n = 1'b0;
                s.mreq_n = hf;
            end
            default: s = STROBES_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fseq_timing.sv
module fseq_timing
    import fetch_seq_pkg::*;
(
    input  logic    clk2x,
    input  logic    rst,
    input  logic    start,
    input  logic    wait_n,
    output tstate_e st,
    output logic    half,
    output logic    start_acc,
    output logic    cap_en,
    output logic    cycle_end
);

    logic wait_q;

    assign start_acc = (st == ST_IDLE) && start;
    assign cap_en    = half && is_read_state(st) && !wait_q;
    assign cycle_end = half && (st == ST_T4);

    always_ff @(posedge clk2x) begin
        if (rst) begin
            st     <= ST_IDLE;
            half   <= 1'b0;
            wait_q <= 1'b0;
        end else if (st == ST_IDLE) begin
            half   <= 1'b0;
            wait_q <= 1'b0;
            if (start) st <= ST_T1;
        end else if (!half) begin
            half <= 1'b1;
            // falling-edge sample of the wait request (R8)
            if (is_read_state(st)) wait_q <= ~wait_n;
        end else begin
            half <= 1'b0;
            case (st)
                ST_T1:        st <= ST_T2;
                ST_T2, ST_TW: st <= wait_q ? ST_TW : ST_T3;
                ST_T3:        st <= ST_T4;
                default:      st <= ST_IDLE;
            endcase
        end
    end

    // R8: a wait state is entered only from a read state
    p_wait_entry_r8: assert property (@(posedge clk2x) disable iff (rst)
        (st == ST_TW && !half) |-> is_read_state(tstate_e'($past(st))));

    // R12: no return to T1 except from idle
    p_start_only_idle_r12: assert property (@(posedge clk2x) disable iff (rst)
        (st == ST_T1 && !half) |-> ($past(st) == ST_IDLE));

endmodule

// File: rtl/fseq_refresh.sv
module fseq_refresh #(
    parameter int RFSH_W = 7
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              step,
    output logic [RFSH_W-1:0] count
);

    always_ff @(posedge clk2x) begin
        if (rst)       count <= '0;
        else if (step) count <= RFSH_W'(count + 1'b1);
    end

    // R11: one increment per completed fetch, wrapping at the top
    p_count_step_r11: assert property (@(posedge clk2x) disable iff (rst)
        $past(step) && !$past(rst) |-> count == RFSH_W'($past(count) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk2x) disable iff (rst)
        !$past(step) && !$past(rst) |-> $stable(count));

endmodule

// File: rtl/fseq_bus.sv
module fseq_bus
    import fetch_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk2x,
    input  logic              rst,
    input  tstate_e           st,
    input  logic              half,
    input  logic              start_acc,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] data_in,
    input  logic [RFSH_W-1:0] rcount,
    output logic [ADDR_W-1:0] addr,
    output strobes_t          strb,
    output logic [DATA_W-1:0] opcode,
    output logic              ir_load
);

    localparam int PAD_W = ADDR_W - RFSH_W;

    logic [ADDR_W-1:0] pc_q;

    always_ff @(posedge clk2x) begin
        if (rst) begin
            pc_q   <= '0;
            opcode <= '0;
        end else begin
            if (start_acc) pc_q   <= pc;
            if (cap_en)    opcode <= data_in;
        end
    end

    always_comb begin
        if (is_refresh_state(st))   addr = {{PAD_W{1'b0}}, rcount};
        else if (st != ST_IDLE)     addr = pc_q;
        else                        addr = '0;
    end

    assign strb    = strobes_for(st, half);
    assign ir_load = (st == ST_T3) && !half;

    // R5: read strobe never active while refreshing
    p_no_read_in_refresh_r5: assert property (@(posedge clk2x) disable iff (rst)
        !strb.rfsh_n |-> strb.rd_n);

    // R7: fetch marker and refresh marker never overlap
    p_m1_rfsh_excl_r7: assert property (@(posedge clk2x) disable iff (rst)
        !(~strb.m1_n && ~strb.rfsh_n));

    // R1: the fetch address stays put across the read phase
    p_addr_stable_r1: assert property (@(posedge clk2x) disable iff (rst)
        is_read_state(st) |-> $stable(addr));

endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
    import fetch_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr,
    output logic              m1_n,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic              ir_load,
    output logic [DATA_W-1:0] opcode,
    output logic              done
);

    tstate_e           st;
    logic              half;
    logic              start_acc;
    logic              cap_en;
    logic              cycle_end;
    logic [RFSH_W-1:0] rcount;
    strobes_t          strb;

    fseq_timing u_timing (
        .clk2x     (clk2x),
        .rst       (rst),
        .start     (start),
        .wait_n    (wait_n),
        .st        (st),
        .half      (half),
        .start_acc (start_acc),
        .cap_en    (cap_en),
        .cycle_end (cycle_end)
    );

    fseq_refresh #(.RFSH_W(RFSH_W)) u_refresh (
        .clk2x (clk2x),
        .rst   (rst),
        .step  (cycle_end),
        .count (rcount)
    );

    fseq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W)) u_bus (
        .clk2x     (clk2x),
        .rst       (rst),
        .st        (st),
        .half      (half),
        .start_acc (start_acc),
        .cap_en    (cap_en),
        .pc        (pc),
        .data_in   (data_in),
        .rcount    (rcount),
        .addr      (addr),
        .strb      (strb),
        .opcode    (opcode),
        .ir_load   (ir_load)
    );

    assign m1_n   = strb.m1_n;
    assign mreq_n = strb.mreq_n;
    assign rd_n   = strb.rd_n;
    assign rfsh_n = strb.rfsh_n;
    assign done   = cycle_end;

    // R3: capture follows a cycle in which the read strobe was active
    p_capture_after_read_r3: assert property (@(posedge clk2x) disable iff (rst)
        ir_load |-> !$past(rd_n));

    // R9: done is a single-cycle pulse followed by idle strobes
    p_done_pulse_r9: assert property (@(posedge clk2x) disable iff (rst)
        done |=> !done && m1_n && mreq_n && rd_n && rfsh_n);

    // R6: memory request rises at the end of the refresh
    p_mreq_refresh_r6: assert property (@(posedge clk2x) disable iff (rst)
        done |-> mreq_n && !rfsh_n);

endmodule

// File: tb/test_fetch_cycle_seq.sv
module test_fetch_cycle_seq;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk2x = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          wait_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic [AW-1:0] addr;
    logic          m1_n, mreq_n, rd_n, rfsh_n, ir_load, done;
    logic [DW-1:0] opcode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    fetch_cycle_seq i_fetch_cycle_seq (
        .clk2x(clk2x), .rst(rst), .start(start), .pc(pc), .wait_n(wait_n),
        .data_in(data_in), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n),
        .rd_n(rd_n), .rfsh_n(rfsh_n), .ir_load(ir_load), .opcode(opcode),
        .done(done)
    );

    always #10 clk2x = ~clk2x;

    // Reference model: phase names 0 idle,1 T1,2 T2,3 TW,4 T3,5 T4
    int m_ph = 0;
    int m_hf = 0;
    int m_cnt = 0;
    int m_pc = 0;
    int m_op = 0;
    bit m_wait = 0;
    int fetches = 0;

    always @(posedge clk2x) begin
        if (rst) begin
            m_ph = 0; m_hf = 0; m_cnt = 0; m_pc = 0; m_op = 0; m_wait = 0;
        end else if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_pc = int'(pc); end
        end else if (m_hf == 0) begin
            m_hf = 1;
            if (m_ph == 2 || m_ph == 3) m_wait = (wait_n == 1'b0);
        end else begin
            m_hf = 0;
            if (m_ph == 1) m_ph = 2;
            else if (m_ph == 2 || m_ph == 3) begin
                if (m_wait) m_ph = 3;
                else begin m_ph = 4; m_op = int'(data_in); end
            end
            else if (m_ph == 4) m_ph = 5;
            else begin m_ph = 0; m_cnt = (m_cnt + 1) % 128; end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge
    always @(negedge clk2x) begin
        int e_addr, e_m1, e_mreq, e_rd, e_rfsh;
        if (!rst && !finished) begin
            e_addr = (m_ph == 0) ? 0 : (m_ph >= 4) ? m_cnt : m_pc;
            e_m1   = (m_ph >= 1 && m_ph <= 3) ? 0 : 1;
            e_rd   = ((m_ph == 1 && m_hf == 1) || m_ph == 2 || m_ph == 3) ? 0 : 1;
            e_mreq = e_rd;
            if (m_ph == 4) e_mreq = (m_hf == 1) ? 0 : 1;
            if (m_ph == 5) e_mreq = (m_hf == 0) ? 0 : 1;
            e_rfsh = (m_ph >= 4) ? 0 : 1;
            if (m_ph >= 4) chk("R4 refresh addr", int'(addr), e_addr);
            else           chk("R1 fetch addr", int'(addr), e_addr);
            chk("R7 m1_n", int'(m1_n), e_m1);
            if (m_ph >= 4) begin
                chk("R5 rd_n in refresh", int'(rd_n), 1);
                chk("R6 mreq_n in refresh", int'(mreq_n), e_mreq);
            end else begin
                chk("R2 rd_n", int'(rd_n), e_rd);
                chk("R2 mreq_n", int'(mreq_n), e_mreq);
            end
            chk("R4 rfsh_n", int'(rfsh_n), e_rfsh);
            chk("R3 ir_load", int'(ir_load), (m_ph == 4 && m_hf == 0) ? 1 : 0);
            chk("R3 opcode", int'(opcode), m_op);
            chk("R9 done", int'(done), (m_ph == 5 && m_hf == 1) ? 1 : 0);
            // R8: phase the model reached, as seen by the fetch marker timing
            if (m_ph == 3) chk("R8 wait state holds read", int'(rd_n), 0);
            // R11: refresh address tracks the number of completed fetches
            if (m_ph == 4 && m_hf == 0) chk("R11 wrap count", int'(addr[6:0]), fetches % 128);
            if (done) fetches++;
        end
        if (rst) fetches = 0;
    end

    task automatic drive(bit s, int p, bit w);
        @(negedge clk2x); #2;
        start = s; pc = AW'(p); wait_n = w; data_in = DW'($urandom);
    endtask

    // One fetch with a given number of wait states, wait_n low in T2/TW first halves
    task automatic fetch(int p, int waits);
        drive(1, p, 1);                     // idle: accepted
        drive(0, p ^ 16'hFFFF, 1);          // T1 h0
        drive(0, 0, 1);                     // T1 h1
        for (int k = 0; k <= waits; k++) begin
            drive((k == 0), 16'h5A5A, (k < waits) ? 1'b0 : 1'b1); // h0 (sampled at next edge)
            drive(0, 0, 1'b0);              // h1: low here must be ignored (R8)
        end
        for (int k = 0; k < 4; k++) drive(0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk2x);
        // R10: reset state
        chk("R10 strobes", int'({m1_n, mreq_n, rd_n, rfsh_n}), 4'hF);
        chk("R10 addr", int'(addr), 0);
        chk("R10 done/ir_load", int'({done, ir_load}), 0);
        chk("R10 opcode", int'(opcode), 0);
        #2 rst = 1'b0;
        fetch(16'h1234, 0);
        fetch(16'hBEEF, 1);
        fetch(16'h0001, 3);
        fetch(16'hFFFF, 0);
        // R12: start held high throughout runs back-to-back and is ignored mid-cycle
        for (int k = 0; k < 40; k++) drive(1, 16'h0100 + k, 1);
        // mid-cycle reset
        drive(1, 16'h4444, 1);
        drive(0, 0, 1);
        drive(0, 0, 1);
        @(negedge clk2x); #2 rst = 1'b1;
        @(negedge clk2x); #2 rst = 1'b0;
        @(negedge clk2x);
        chk("R10 after reset", int'({m1_n, mreq_n, rd_n, rfsh_n, done}), 5'h1E);
        // random traffic, enough fetches to wrap the refresh count (R11)
        for (int k = 0; k < 6000; k++)
            drive(($urandom % 3) != 0, int'($urandom), ($urandom % 3) != 0);
        drive(0, 0, 1);
        repeat (40) drive(0, 0, 1);
        chk("R11 enough fetches to wrap", (fetches > 128) ? 1 : 0, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk2x) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule